// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host side of a link to a 12-bit successive-approximation converter that talks over a four-wire serial port. Each conversion takes one frame: chip select low, sixteen serial clocks, chip select high. During the first eight clocks the block shifts out an 8-bit command word. During all sixteen it samples the converter's data line. It keeps only the last twelve bits sampled and presents them with a one-cycle valid strobe.

The block keeps track of the converter's power state. The command word holds a power-mode field. If the mode last written leaves the converter asleep, the next request first runs a wake-up frame whose result is thrown away. It then holds chip select high for a programmed settling time before it runs the real conversion frame. The converter applies a command to the sample it takes in the following frame. For this reason each result carries the channel bit of the command word sent in the frame before it.

Requests arrive as single-cycle pulses with a command word, or from an automatic mode that repeats frames with a programmable idle gap. The serial clock rate comes from a divider setting that is latched at the start of each frame.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset, chip select and the serial clock are both high, and the result valid strobe is low.
- R2: Each frame holds chip select low for exactly 16 rising serial clock edges. The serial clock is high whenever chip select is high.
- R3: Each high and each low phase of the serial clock lasts N+1 system clocks, where N is the divider value latched when the frame starts. The first falling edge comes N+1 clocks after chip select falls.
- R4: The data-in line changes only on falling serial clock edges. It carries the 8-bit command MSB first, one bit on each of the first eight rising edges, and is 0 for the remaining eight.
- R5: The result is the last 12 bits sampled on rising edges, MSB first. The first four sampled bits have no effect on it, whatever their value.
- R6: The valid strobe lasts exactly one cycle and fires once per conversion frame. The channel tag equals bit 5 of the command word sent in the frame just before that conversion frame. It is 0 if no earlier frame exists.
- R7: Bits [1:0] of the command are the power mode. The value 01 keeps the converter awake, and any other value leaves it asleep after the frame. When a frame is due while the converter is asleep, the block first sends the same command in a wake frame that produces no strobe. It then keeps chip select high for at least WAKE_CYC clocks and runs the conversion frame.
- R8: A start pulse that arrives while a frame is running is held. A later pulse replaces the held command. The held frame begins only after chip select has been high for at least 2(N+1) clocks.
- R9: While auto mode is on, frames repeat with chip select high for at least max(gap, 2(N+1)) clocks between them, using the live command input. When auto mode goes off, no new frame starts.
- R10: After reset the converter is taken to be asleep, so the first request produces a wake frame before its conversion frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle conversion request |
| ctrl_i | input | 8 | Command word: [5] channel, [1:0] power mode |
| div_i | input | DIV_W | Serial clock divider N |
| auto_i | input | 1 | Repeat frames continuously while high |
| gap_i | input | GAP_W | Minimum chip-select-high clocks in auto mode |
| dout_i | input | 1 | Serial data from converter |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| din_o | output | 1 | Serial data to converter |
| result_o | output | 12 | Conversion result |
| result_chan_o | output | 1 | Channel tag of the result |
| result_valid_o | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that dout_i changes only after falling serial clock edges, so it is settled at each rising edge. They also assume that WAKE_CYC and every gap value fit below the saturation point of the idle counter, since otherwise the idle timer would never qualify a launch. The bench's converter model updates its data line only on falling serial clock edges. All inputs are driven on the falling system clock edge, and the bench keeps the divider and gap values small enough that the idle counter never saturates.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    localparam int CMD_W      = 8;
    localparam int RES_W      = 12;
    localparam int FRAME_BITS = 16;
    localparam int EDGE_W     = $clog2(2 * FRAME_BITS + 1);

    // command word fields decoded by the sequencer
    localparam int         CHAN_BIT = 5;
    localparam logic [1:0] PM_AWAKE = 2'b01;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_FRAME = 1'b1
    } seq_state_e;

    function automatic logic mode_sleeps(input logic [CMD_W-1:0] w);
        return w[1:0] != PM_AWAKE;
    endfunction

endpackage

// File: rtl/adc_host_clkdiv.sv
module adc_host_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t d, q;

    always_comb begin
        d      = q;
        tick_o = 1'b0;
        if (clr_i) begin
            d.cnt = '0;
        end else if (run_i) begin
            if (q.cnt == div_i) begin
                d.cnt  = '0;
                tick_o = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && !clr_i |-> q.cnt <= div_i); // R3

endmodule

// File: rtl/adc_host_gaptimer.sv
module adc_host_gaptimer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [GAP_W-1:0] cnt_o
);

    localparam logic [GAP_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [GAP_W-1:0] cnt;
    } gap_t;

    gap_t d, q;

    always_comb begin
        d = q;
        if (clr_i)                d.cnt = '0;
        else if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o = q.cnt;

endmodule

// File: rtl/adc_host_shifter.sv
module adc_host_shifter
    import adc_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             tick_i,
    input  logic             dout_i,
    output logic             sclk_o,
    output logic             din_o,
    output logic             active_o,
    output logic             done_o,
    output logic [RES_W-1:0] word_o
);

    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * FRAME_BITS);

    typedef struct packed {
        logic              active;
        logic              sclk;
        logic              din;
        logic              done;
        logic [EDGE_W-1:0] edges;
        logic [CMD_W-1:0]  cmd;
        logic [RES_W-1:0]  sh;
    } shf_t;

    localparam shf_t SHF_RST = '{
        active: 1'b0, sclk: 1'b1, din: 1'b0, done: 1'b0,
        edges: '0, cmd: '0, sh: '0
    };

    shf_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (load_i) begin
            d.active = 1'b1;
            d.sclk   = 1'b1;
            d.din    = 1'b0;
            d.edges  = '0;
            d.cmd    = cmd_i;
            d.sh     = '0;
        end else if (q.active && tick_i) begin
            if (q.edges == LAST_EDGE) begin
                // trailing half period with clock high, then release
                d.active = 1'b0;
                d.done   = 1'b1;
            end else begin
                d.edges = q.edges + 1'b1;
                if (q.sclk) begin
                    d.sclk = 1'b0;
                    d.din  = q.cmd[CMD_W-1];
                    d.cmd  = {q.cmd[CMD_W-2:0], 1'b0};
                end else begin
                    d.sclk = 1'b1;
                    d.sh   = {q.sh[RES_W-2:0], dout_i};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SHF_RST;
        else        q <= d;
    end

    assign sclk_o   = q.sclk;
    assign din_o    = q.din;
    assign active_o = q.active;
    assign done_o   = q.done;
    assign word_o   = q.sh;

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !q.active); // R8

    AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        q.active && !tick_i && !load_i |=> $stable(q.sclk)); // R3

    AST_DIN_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        q.active && !q.sclk && tick_i |=> $stable(q.din)); // R4

endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int GAP_W    = 16,
    parameter int WAKE_CYC = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CMD_W-1:0] ctrl_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             auto_i,
    input  logic [GAP_W-1:0] gap_i,
    input  logic             dout_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             din_o,
    output logic [RES_W-1:0] result_o,
    output logic             result_chan_o,
    output logic             result_valid_o
);

    localparam logic [31:0] WAKE_W = 32'(WAKE_CYC);

    typedef struct packed {
        seq_state_e       state;
        logic             cs_n;
        logic [CMD_W-1:0] cur_cmd;
        logic [CMD_W-1:0] req_cmd;
        logic             pend;
        logic [DIV_W-1:0] div_cur;
        logic             dummy;
        logic             wake_done;
        logic             asleep;
        logic             prev_chan;
        logic [RES_W-1:0] res;
        logic             res_chan;
        logic             res_valid;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state: SEQ_IDLE, cs_n: 1'b1, cur_cmd: '0, req_cmd: '0, pend: 1'b0,
        div_cur: '0, dummy: 1'b0, wake_done: 1'b0, asleep: 1'b1,
        prev_chan: 1'b0, res: '0, res_chan: 1'b0, res_valid: 1'b0
    };

    seq_t d, q;

    logic             launch;
    logic             gap_clr;
    logic             tick;
    logic             shf_sclk;
    logic             shf_active;
    logic             shf_done;
    logic [RES_W-1:0] shf_word;
    logic [GAP_W-1:0] gap_cnt;
    logic [31:0]      span_w;
    logic [31:0]      gapi_w;
    logic [31:0]      gapc_w;
    logic [31:0]      need_w;

    always_comb begin
        span_w = ({{(32-DIV_W){1'b0}}, q.div_cur} + 32'd1) << 1;
        gapi_w = {{(32-GAP_W){1'b0}}, gap_i};
        gapc_w = {{(32-GAP_W){1'b0}}, gap_cnt};
        if (q.wake_done) need_w = (WAKE_W > span_w) ? WAKE_W : span_w;
        else             need_w = (gapi_w > span_w) ? gapi_w : span_w;
    end

    always_comb begin
        d           = q;
        d.res_valid = 1'b0;
        launch      = 1'b0;
        gap_clr     = 1'b0;

        if (start_i) begin
            d.req_cmd = ctrl_i;
            d.pend    = 1'b1;
        end

        case (q.state)
            SEQ_IDLE: begin
                if (gapc_w >= need_w) begin
                    if (q.wake_done) begin
                        // conversion frame after the wake frame, same command
                        launch      = 1'b1;
                        d.dummy     = 1'b0;
                        d.wake_done = 1'b0;
                    end else if (q.pend || auto_i) begin
                        launch    = 1'b1;
                        d.cur_cmd = q.pend ? q.req_cmd : ctrl_i;
                        d.div_cur = div_i;
                        d.dummy   = q.asleep;
                        d.pend    = start_i;
                    end
                end
                if (launch) begin
                    d.state = SEQ_FRAME;
                    d.cs_n  = 1'b0;
                end
            end
            SEQ_FRAME: begin
                if (shf_done) begin
                    gap_clr     = 1'b1;
                    d.state     = SEQ_IDLE;
                    d.cs_n      = 1'b1;
                    d.prev_chan = q.cur_cmd[CHAN_BIT];
                    if (q.dummy) begin
                        d.wake_done = 1'b1;
                    end else begin
                        d.res       = shf_word;
                        d.res_chan  = q.prev_chan;
                        d.res_valid = 1'b1;
                        d.asleep    = mode_sleeps(q.cur_cmd);
                    end
                end
            end
            default: d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    adc_host_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (launch),
        .run_i  (shf_active),
        .div_i  (q.div_cur),
        .tick_o (tick)
    );

    adc_host_shifter u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (launch),
        .cmd_i    (d.cur_cmd),
        .tick_i   (tick),
        .dout_i   (dout_i),
        .sclk_o   (shf_sclk),
        .din_o    (din_o),
        .active_o (shf_active),
        .done_o   (shf_done),
        .word_o   (shf_word)
    );

    adc_host_gaptimer #(.GAP_W(GAP_W)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (gap_clr),
        .cnt_o (gap_cnt)
    );

    assign cs_n_o         = q.cs_n;
    assign sclk_o         = shf_sclk;
    assign result_o       = q.res;
    assign result_chan_o  = q.res_chan;
    assign result_valid_o = q.res_valid;

    // independent count of chip-select-high cycles, used only by assertions
    logic [31:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       hi_cnt_q <= '0;
        else if (!q.cs_n)                 hi_cnt_q <= '0;
        else if (hi_cnt_q != 32'hFFFF_FFFF) hi_cnt_q <= hi_cnt_q + 32'd1;
    end

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        q.cs_n |-> shf_sclk); // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.res_valid |=> !q.res_valid); // R6

    AST_VALID_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        q.res_valid |-> q.cs_n && $past(!q.cs_n)); // R6

    AST_CS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.cs_n) |-> $past(hi_cnt_q) >= $past(span_w)); // R8

    AST_WAKE_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.cs_n) && $past(q.wake_done) |-> $past(hi_cnt_q) >= WAKE_W); // R7

endmodule

// File: tb/adc_host_ctrl_tb.sv
module adc_host_ctrl_tb;

    localparam int DIV_W = 8;
    localparam int GAP_W = 16;
    localparam int WAKE  = 250;
    localparam int TCLK  = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [7:0]       ctrl_i = 8'h00;
    logic [DIV_W-1:0] div_i = 8'd3;
    logic             auto_i = 1'b0;
    logic [GAP_W-1:0] gap_i = '0;
    logic             dout_i = 1'b0;
    logic             cs_n_o, sclk_o, din_o;
    logic [11:0]      result_o;
    logic             result_chan_o, result_valid_o;

    always #(TCLK/2) clk = ~clk;

    adc_host_ctrl #(.DIV_W(DIV_W), .GAP_W(GAP_W), .WAKE_CYC(WAKE)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
        .div_i(div_i), .auto_i(auto_i), .gap_i(gap_i), .dout_i(dout_i),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .din_o(din_o), .result_o(result_o),
        .result_chan_o(result_chan_o), .result_valid_o(result_valid_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    logic [3:0]  lead = 4'h0;
    logic [11:0] adc_val = 12'h000;
    logic [15:0] fword;
    int  s_bit, s_rises, frames, last_rises;
    logic [15:0] s_din, last_din;
    time t_edge, t_rise;
    bit  have_rise = 0;
    int  hp_min, hp_max, last_gap, gap_min;

    always @(negedge cs_n_o) if (rst_n) begin
        fword   = {lead, adc_val};
        s_bit   = 0;
        s_rises = 0;
        s_din   = '0;
        t_edge  = $time;
        hp_min  = 1 << 30;
        hp_max  = 0;
        if (have_rise) begin
            last_gap = int'(($time - t_rise) / TCLK);
            if (last_gap < gap_min) gap_min = last_gap;
        end
    end

    always @(negedge sclk_o) if (rst_n && !cs_n_o) begin
        int hp;
        hp = int'(($time - t_edge) / TCLK);
        if (hp < hp_min) hp_min = hp;
        if (hp > hp_max) hp_max = hp;
        t_edge = $time;
        dout_i = (s_bit < 16) ? fword[15 - s_bit] : 1'b0;
        s_bit++;
    end

    always @(posedge sclk_o) if (rst_n && !cs_n_o) begin
        int hp;
        hp = int'(($time - t_edge) / TCLK);
        if (hp < hp_min) hp_min = hp;
        if (hp > hp_max) hp_max = hp;
        t_edge = $time;
        s_din = {s_din[14:0], din_o};
        s_rises++;
    end

    always @(posedge cs_n_o) if (rst_n) begin
        frames++;
        last_din   = s_din;
        last_rises = s_rises;
        t_rise     = $time;
        have_rise  = 1;
    end

    // ---------------- result monitor ----------------
    int n_valid = 0;
    int run_len = 0;
    int max_run = 0;
    logic [11:0] res_log [16];
    logic        chan_log [16];

    always @(negedge clk) begin
        if (result_valid_o) begin
            res_log[n_valid & 15]  = result_o;
            chan_log[n_valid & 15] = result_chan_o;
            n_valid++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic pulse_start(input logic [7:0] c);
        @(negedge clk);
        ctrl_i  = c;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_results(input int n, input int limit);
        int base;
        base = n_valid;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (n_valid >= base + n) break;
        end
        repeat (4) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(cs_n_o == 1'b1, "R1 cs_n", cs_n_o, 1);
        chk(sclk_o == 1'b1, "R1 sclk", sclk_o, 1);
        chk(result_valid_o == 1'b0, "R1 valid", result_valid_o, 0);
    endtask

    task automatic t_first_wake();
        int f0, v0;
        f0 = frames; v0 = n_valid;
        adc_val = 12'hA5C;
        pulse_start(8'h01);
        wait_results(1, 3000);
        chk(frames - f0 == 2, "R10 wake frame count", frames - f0, 2);
        chk(n_valid - v0 == 1, "R7 one strobe", n_valid - v0, 1);
        chk(res_log[v0 & 15] == 12'hA5C, "R5 result", res_log[v0 & 15], 12'hA5C);
        chk(last_gap >= WAKE, "R7 wake settle", last_gap, WAKE);
        chk(last_din == 16'h0100, "R4 din word", last_din, 16'h0100);
        chk(last_rises == 16, "R2 rising edges", last_rises, 16);
        chk(hp_min == 4 && hp_max == 4, "R3 half period div3", hp_max, 4);
        chk(chan_log[v0 & 15] == 1'b0, "R6 tag after wake", chan_log[v0 & 15], 0);
    endtask

    task automatic t_tag();
        int f0, v0;
        f0 = frames; v0 = n_valid;
        adc_val = 12'h123;
        pulse_start(8'h21);
        wait_results(1, 3000);
        chk(frames - f0 == 1, "R7 awake no wake", frames - f0, 1);
        chk(res_log[v0 & 15] == 12'h123, "R5 result", res_log[v0 & 15], 12'h123);
        chk(chan_log[v0 & 15] == 1'b0, "R6 tag prev 0", chan_log[v0 & 15], 0);
        adc_val = 12'hFFF;
        pulse_start(8'h01);
        wait_results(1, 3000);
        chk(res_log[(v0 + 1) & 15] == 12'hFFF, "R5 result", res_log[(v0 + 1) & 15], 12'hFFF);
        chk(chan_log[(v0 + 1) & 15] == 1'b1, "R6 tag prev 1", chan_log[(v0 + 1) & 15], 1);
    endtask

    task automatic t_lead();
        int v0;
        v0 = n_valid;
        lead = 4'hF; adc_val = 12'h000;
        pulse_start(8'h01);
        wait_results(1, 3000);
        chk(res_log[v0 & 15] == 12'h000, "R5 leading ones ignored", res_log[v0 & 15], 0);
        lead = 4'hA; adc_val = 12'h5A5;
        pulse_start(8'h01);
        wait_results(1, 3000);
        chk(res_log[(v0 + 1) & 15] == 12'h5A5, "R5 leading bits ignored", res_log[(v0 + 1) & 15], 12'h5A5);
        lead = 4'h0;
    endtask

    task automatic t_div();
        @(negedge clk);
        div_i = 8'd1;
        pulse_start(8'h01);
        wait_results(1, 3000);
        chk(hp_min == 2 && hp_max == 2, "R3 half period div1", hp_max, 2);
        chk(last_rises == 16, "R2 rising edges div1", last_rises, 16);
        div_i = 8'd3;
    endtask

    task automatic t_sleep();
        int f0, v0;
        f0 = frames; v0 = n_valid;
        adc_val = 12'h321;
        pulse_start(8'h00);
        wait_results(1, 3000);
        chk(frames - f0 == 1, "R7 sleep write one frame", frames - f0, 1);
        chk(res_log[v0 & 15] == 12'h321, "R5 result", res_log[v0 & 15], 12'h321);
        f0 = frames;
        adc_val = 12'h654;
        pulse_start(8'h21);
        wait_results(1, 3000);
        chk(frames - f0 == 2, "R7 wake after sleep", frames - f0, 2);
        chk(n_valid - v0 == 2, "R7 wake frame silent", n_valid - v0, 2);
        chk(last_gap >= WAKE, "R7 wake settle", last_gap, WAKE);
        chk(chan_log[(v0 + 1) & 15] == 1'b1, "R6 tag from wake word", chan_log[(v0 + 1) & 15], 1);
    endtask

    task automatic t_pending();
        int f0, v0;
        f0 = frames; v0 = n_valid;
        adc_val = 12'h111;
        pulse_start(8'h01);
        repeat (20) @(negedge clk);
        chk(cs_n_o == 1'b0, "R8 frame running", cs_n_o, 0);
        pulse_start(8'h21);
        repeat (3) @(negedge clk);
        pulse_start(8'h31);
        wait_results(2, 4000);
        chk(frames - f0 == 2, "R8 two frames", frames - f0, 2);
        chk(n_valid - v0 == 2, "R8 two results", n_valid - v0, 2);
        chk(last_din == 16'h3100, "R8 latest command", last_din, 16'h3100);
        chk(last_gap >= 8, "R8 min cs high", last_gap, 8);
    endtask

    task automatic t_auto();
        int v0, f1;
        v0 = n_valid;
        @(negedge clk);
        gap_min = 1 << 30;
        ctrl_i = 8'h01; gap_i = 16'd40; auto_i = 1'b1;
        wait_results(3, 5000);
        chk(n_valid - v0 >= 3, "R9 auto results", n_valid - v0, 3);
        chk(gap_min >= 40, "R9 programmed gap", gap_min, 40);
        gap_min = 1 << 30;
        gap_i = 16'd2;
        v0 = n_valid;
        wait_results(3, 5000);
        chk(gap_min >= 8, "R9 gap floor", gap_min, 8);
        auto_i = 1'b0;
        repeat (300) @(negedge clk);
        f1 = frames;
        repeat (300) @(negedge clk);
        chk(frames == f1 && cs_n_o, "R9 auto stops", frames - f1, 0);
        chk(max_run == 1, "R6 strobe width", max_run, 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        gap_min  = 1 << 30;
        last_gap = 0;
        frames   = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_wake();
        t_tag();
        t_lead();
        t_div();
        t_sleep();
        t_pending();
        t_auto();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule